// File: doc/BRIEF.md
# Shadow Register Bank with Serial Commit

This block holds a local copy of the configuration registers of an external device that is reached over a serial control bus. The host reads and changes the local copy through a simple request/response port. Each entry has a dirty flag. A commit request sends only the changed entries to the device, lowest address first. A direct write goes out to the device at once. A read is answered from the local copy unless the device holds the only valid value.

On the device side the block hands out one transaction at a time. A transaction is a pair of words: a command word that carries a read flag and the register address, followed by a data word. The requester holds the pair until the serial engine acknowledges it. On that acknowledge the engine also returns the word it received from the device. The bit-level serial engine sits outside this block. An initialisation request reloads every entry from its default and pushes the whole bank to the device.

Top module: `shadow_bank`

## Requirements
- R1: After reset, `busy`, `bus_req` and `rsp_valid` are low and `req_ready` is high. Every entry holds its default value and every entry is marked dirty. No bus traffic starts until a request is accepted.
- R2: The default of entry i is 0xC35A XOR (i * 0x0111), truncated to 16 bits. Asserting `init_req` while idle reloads all defaults and marks all 31 entries dirty. It then writes all 31 entries to the device in ascending address order and finishes with one `rsp_valid` pulse.
- R3: Command word format: bit 7 is 1 for a read and 0 for a write, and bits 6:0 carry the register address. All other bits of the command word are 0. A write sends the value in the data word. A read sends 0xFFFF in the data word. `bus_req`, `bus_cmd` and `bus_wdata` stay stable until the cycle in which `bus_ack` is high.
- R4: Commit (op 2'b11) writes only the dirty entries, in ascending address order. It clears each dirty flag when that entry's transfer is acknowledged. A commit with no dirty entries issues no transfer and still responds.
- R5: A direct write (op 2'b01) to an address below 31 updates the entry and issues exactly one write transfer at once. It leaves the entry clean.
- R6: A field update (op 2'b10) to an address below 31 replaces the low byte when `req_be[0]` is set and the high byte when `req_be[1]` is set. It marks the entry dirty and causes no bus traffic.
- R7: A read (op 2'b00) of a clean entry returns the local value with `rsp_valid` one cycle after acceptance. It causes no bus traffic.
- R8: A read of a dirty entry fetches the value from the device, overwrites the local entry (the pending change is discarded), clears the dirty flag and returns the fetched value.
- R9: A read of address 31 always performs a device read and returns the fetched word, on every read.
- R10: Writes and updates to addresses 31 and above, and reads of addresses 32 and above, respond with `rsp_err` high and issue no transfer.
- R11: While a commit, an initialisation or a transfer is in progress, `busy` is high and `req_ready` is low. A request held valid during that time is accepted after the current operation completes, and is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req | input | 1 | Reload defaults and commit the whole bank; taken when idle, ahead of `req_valid` |
| req_valid | input | 1 | Host request valid; hold until accepted |
| req_op | input | 2 | 00 read, 01 write, 10 field update, 11 commit |
| req_addr | input | 7 | Register address |
| req_wdata | input | 16 | Write or update data |
| req_be | input | 2 | Byte enables for a field update |
| req_ready | output | 1 | Request is accepted on this cycle's clock edge |
| busy | output | 1 | Commit, initialisation or transfer in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Address rejected; valid with `rsp_valid` |
| rsp_rdata | output | 16 | Read result; valid with `rsp_valid` |
| bus_req | output | 1 | Transaction pending for the serial engine |
| bus_cmd | output | 16 | Command word |
| bus_wdata | output | 16 | Data word sent to the device |
| bus_ack | input | 1 | Transaction finished |
| bus_rdata | input | 16 | Word returned by the device, valid with `bus_ack` |

## Verification
The bench changes a device-side value behind the bank's back and then reads a dirty entry. A design that serves that read from the local copy returns the stale local value instead of the device word. Repeated reads of address 31 must each produce a fresh bus read with a new value; a design that caches that address returns the first value twice. Three field updates with different byte masks are followed by a commit. The bench checks the write order and the merged data, which catches a design that writes clean entries, scans in the wrong order or merges the wrong byte. A write held valid during a commit must appear on the bus after the commit's writes; a design that dropped stalled requests would never produce it.

// File: rtl/shadow_pkg.sv
// Shared types and default-value function for the shadow register bank.
// Assumes entries are at most 16 bits wide for the default formula.
package shadow_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_UPDATE = 2'b10,
        OP_COMMIT = 2'b11
    } host_op_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_XFER
    } bank_state_t;

    typedef enum logic [1:0] {
        XK_COMMIT,
        XK_DIRECT,
        XK_FILL,
        XK_PROBE
    } xfer_kind_t;

    // Power-on / initialisation value of entry idx.
    function automatic logic [15:0] entry_default(input int idx);
        logic [15:0] i16;
        i16 = 16'(idx);
        return 16'hC35A ^ (i16 * 16'h0111);
    endfunction

endpackage

// File: rtl/shadow_store.sv
// Storage array plus dirty flags for the shadow bank.
// Assumes mark and clean requests never target the same cycle (the
// controller issues marks only when idle and cleans only during a transfer).
module shadow_store
    import shadow_pkg::*;
#(
    parameter int NUM_REGS = 31,
    parameter int DATA_W   = 16,
    parameter int IDX_W    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_all,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DATA_W/8-1:0]   wr_be,
    input  logic                  mark_en,
    input  logic                  clean_en,
    input  logic [IDX_W-1:0]      clean_idx,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_dirty,
    output logic [NUM_REGS-1:0]   dirty
);

    localparam int BYTES = DATA_W / 8;

    logic [DATA_W-1:0] mem [NUM_REGS];

    for (genvar e = 0; e < NUM_REGS; e++) begin : g_entry
        // Holds one entry: reset/reload to default, byte-masked write.
        always_ff @(posedge clk) begin
            if (!rst_n || load_all) begin
                mem[e] <= DATA_W'(entry_default(e));
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (wr_be[b]) mem[e][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end

        // Tracks whether the entry differs from the device copy.
        always_ff @(posedge clk) begin
            if (!rst_n || load_all) begin
                dirty[e] <= 1'b1;
            end else if (mark_en && wr_en && wr_idx == IDX_W'(e)) begin
                dirty[e] <= 1'b1;
            end else if (clean_en && clean_idx == IDX_W'(e)) begin
                dirty[e] <= 1'b0;
            end
        end
    end

    // Read port, returning zero for indices outside the array.
    always_comb begin
        rd_data  = '0;
        rd_dirty = 1'b0;
        for (int e = 0; e < NUM_REGS; e++) begin
            if (rd_idx == IDX_W'(e)) begin
                rd_data  = mem[e];
                rd_dirty = dirty[e];
            end
        end
    end

    AST_MARK_CLEAN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mark_en && clean_en)); // R6

endmodule

// File: rtl/dirty_scan.sv
// Lowest-set-bit finder used by the commit sequencer to walk dirty entries
// in ascending order. Purely combinational.
module dirty_scan #(
    parameter int WIDTH = 31,
    parameter int IDX_W = 5
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Priority pick: the loop runs downward so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/shadow_bank.sv
// Shadow register bank with serial commit.
// Keeps a dirty-tracked local copy of an external device's registers and
// generates two-word serial transactions (command, data) toward a serial
// engine. Assumes DATA_W > ADDR_W so the read flag fits above the address,
// and that the last address (NUM_REGS) is the uncached readback register.
module shadow_bank
    import shadow_pkg::*;
#(
    parameter int NUM_REGS = 31,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_req,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                req_ready,
    output logic                busy,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                bus_req,
    output logic [DATA_W-1:0]   bus_cmd,
    output logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_ack,
    input  logic [DATA_W-1:0]   bus_rdata
);

    localparam int                IDX_W   = $clog2(NUM_REGS + 1);
    localparam int                BYTES   = DATA_W / 8;
    localparam logic [ADDR_W-1:0] RB_ADDR = ADDR_W'(NUM_REGS);

    bank_state_t         state;
    xfer_kind_t          kind;
    logic [IDX_W-1:0]    cur_idx;

    logic                accept;
    logic                addr_ok;
    logic                is_rb;
    logic [IDX_W-1:0]    req_idx;
    logic                xfer_end;

    logic                st_load;
    logic                st_wen;
    logic [IDX_W-1:0]    st_widx;
    logic [DATA_W-1:0]   st_wdata;
    logic [BYTES-1:0]    st_wbe;
    logic                st_mark;
    logic                st_clean;
    logic [IDX_W-1:0]    st_ridx;
    logic [DATA_W-1:0]   st_rdata;
    logic                st_rdirty;
    logic [NUM_REGS-1:0] dirty;
    logic                scan_found;
    logic [IDX_W-1:0]    scan_idx;

    // Builds a command word: read flag above the address field.
    function automatic logic [DATA_W-1:0] mk_cmd(input logic rd, input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] w;
        w         = '0;
        w[ADDR_W] = rd;
        w[ADDR_W-1:0] = a;
        return w;
    endfunction

    // Request decode and store control.
    always_comb begin
        accept   = (state == ST_IDLE) && req_valid && !init_req;
        addr_ok  = req_addr < RB_ADDR;
        is_rb    = req_addr == RB_ADDR;
        req_idx  = req_addr[IDX_W-1:0];
        xfer_end = (state == ST_XFER) && bus_ack;

        st_load  = (state == ST_IDLE) && init_req;
        st_mark  = accept && addr_ok && (req_op == OP_UPDATE);
        st_wen   = (accept && addr_ok && (req_op == OP_WRITE || req_op == OP_UPDATE))
                 || (xfer_end && kind == XK_FILL);
        st_widx  = (state == ST_XFER) ? cur_idx : req_idx;
        st_wdata = (state == ST_XFER) ? bus_rdata : req_wdata;
        st_wbe   = (state == ST_IDLE && req_op == OP_UPDATE) ? req_be : '1;
        st_clean = xfer_end && kind != XK_PROBE;
        st_ridx  = (state == ST_SCAN) ? scan_idx : req_idx;
    end

    assign req_ready = (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);

    shadow_store #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_all  (st_load),
        .wr_en     (st_wen),
        .wr_idx    (st_widx),
        .wr_data   (st_wdata),
        .wr_be     (st_wbe),
        .mark_en   (st_mark),
        .clean_en  (st_clean),
        .clean_idx (cur_idx),
        .rd_idx    (st_ridx),
        .rd_data   (st_rdata),
        .rd_dirty  (st_rdirty),
        .dirty     (dirty)
    );

    dirty_scan #(
        .WIDTH (NUM_REGS),
        .IDX_W (IDX_W)
    ) i_scan (
        .vec   (dirty),
        .found (scan_found),
        .idx   (scan_idx)
    );

    // Sequencer: accepts host requests, walks dirty entries, runs transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= XK_COMMIT;
            cur_idx   <= '0;
            bus_req   <= 1'b0;
            bus_cmd   <= '0;
            bus_wdata <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (init_req) begin
                        state <= ST_SCAN;
                    end else if (req_valid) begin
                        cur_idx <= req_idx;
                        unique case (req_op)
                            OP_READ: begin
                                if (is_rb || (addr_ok && st_rdirty)) begin
                                    bus_req   <= 1'b1;
                                    bus_cmd   <= mk_cmd(1'b1, req_addr);
                                    bus_wdata <= '1;
                                    kind      <= is_rb ? XK_PROBE : XK_FILL;
                                    state     <= ST_XFER;
                                end else begin
                                    rsp_valid <= 1'b1;
                                    rsp_err   <= !addr_ok;
                                    rsp_rdata <= addr_ok ? st_rdata : '0;
                                end
                            end
                            OP_WRITE: begin
                                if (addr_ok) begin
                                    bus_req   <= 1'b1;
                                    bus_cmd   <= mk_cmd(1'b0, req_addr);
                                    bus_wdata <= req_wdata;
                                    kind      <= XK_DIRECT;
                                    state     <= ST_XFER;
                                end else begin
                                    rsp_valid <= 1'b1;
                                    rsp_err   <= 1'b1;
                                end
                            end
                            OP_UPDATE: begin
                                rsp_valid <= 1'b1;
                                rsp_err   <= !addr_ok;
                            end
                            default: begin
                                state <= ST_SCAN;
                            end
                        endcase
                    end
                end
                ST_SCAN: begin
                    if (scan_found) begin
                        bus_req   <= 1'b1;
                        bus_cmd   <= mk_cmd(1'b0, ADDR_W'(scan_idx));
                        bus_wdata <= st_rdata;
                        cur_idx   <= scan_idx;
                        kind      <= XK_COMMIT;
                        state     <= ST_XFER;
                    end else begin
                        rsp_valid <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: begin
                    if (bus_ack) begin
                        bus_req <= 1'b0;
                        if (kind == XK_COMMIT) begin
                            state <= ST_SCAN;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= (kind == XK_DIRECT) ? '0 : bus_rdata;
                            state     <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_cmd) && $stable(bus_wdata))); // R3
    AST_READ_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd[ADDR_W]) |-> (bus_wdata == '1)); // R3
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd[ADDR_W-1:0] <= RB_ADDR)); // R10
    AST_RB_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd[ADDR_W-1:0] == RB_ADDR) |-> bus_cmd[ADDR_W]); // R9
    AST_BUS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (busy && !req_ready)); // R11
    AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid); // R10

endmodule

// File: tb/test_shadow_bank.sv
// Directed bench: one task per scenario; a simple serial engine model
// acknowledges each transaction after a fixed latency and logs it.
module test_shadow_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_req = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [6:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, busy, rsp_valid, rsp_err;
    logic [15:0] rsp_rdata;
    logic        bus_req;
    logic [15:0] bus_cmd, bus_wdata;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] got_data;
    logic        got_err;

    logic [15:0] dev_mem [32];
    logic [15:0] log_cmd [256];
    logic [15:0] log_dat [256];
    int          log_n = 0;
    int          lat_cnt = 0;
    logic [15:0] rb_ctr = 16'hA000;

    always #10 clk = ~clk;

    shadow_bank i_shadow_bank (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .req_valid(req_valid),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .bus_req(bus_req), .bus_cmd(bus_cmd),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    function automatic logic [15:0] def_val(input int i);
        return 16'hC35A ^ (16'(i) * 16'h0111);
    endfunction

    // Serial engine model: acknowledges after three cycles and logs traffic.
    initial begin
        for (int i = 0; i < 32; i++) dev_mem[i] = 16'h5000 + 16'(i);
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
                lat_cnt = 0;
            end else if (bus_req) begin
                lat_cnt++;
                if (lat_cnt == 3) begin
                    if (log_n < 256) begin
                        log_cmd[log_n] = bus_cmd;
                        log_dat[log_n] = bus_wdata;
                    end
                    log_n++;
                    if (bus_cmd[7]) begin
                        if (bus_cmd[6:0] == 7'd31) begin
                            bus_rdata = rb_ctr;
                            rb_ctr++;
                        end else begin
                            bus_rdata = dev_mem[bus_cmd[4:0]];
                        end
                    end else begin
                        dev_mem[bus_cmd[4:0]] = bus_wdata;
                        bus_rdata = 16'h0000;
                    end
                    bus_ack = 1'b1;
                end
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wait_rsp();
        while (!rsp_valid) @(negedge clk);
        got_data = rsp_rdata;
        got_err  = rsp_err;
    endtask

    task automatic host_op(input logic [1:0] op, input logic [6:0] a,
                           input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_rsp();
    endtask

    task automatic run_init();
        @(negedge clk);
        init_req = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        init_req = 1'b0;
        wait_rsp();
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", busy, 0);
        chk("R1 req_ready after reset", req_ready, 1);
        chk("R1 bus_req after reset", bus_req, 0);
        chk("R1 rsp_valid after reset", rsp_valid, 0);
        chk("R1 no traffic after reset", log_n, 0);
        // All entries dirty at reset: a read must fetch from the device.
        host_op(2'b00, 7'd2, 16'h0, 2'b00);
        chk("R1 read after reset goes to bus", log_n, 1);
        chk("R1 read after reset returns device word", got_data, 16'h5002);
    endtask

    task automatic t_init();
        int base;
        base = log_n;
        run_init();
        chk("R2 init transfer count", log_n - base, 31);
        for (int i = 0; i < 31; i++) begin
            chk($sformatf("R2 init cmd order entry %0d", i), log_cmd[base + i], 16'(i));
            chk($sformatf("R2 init default entry %0d", i), log_dat[base + i], def_val(i));
        end
        base = log_n;
        host_op(2'b11, 7'd0, 16'h0, 2'b00);
        chk("R4 commit with nothing dirty issues no transfer", log_n - base, 0);
        host_op(2'b00, 7'd17, 16'h0, 2'b00);
        chk("R7 clean read value", got_data, def_val(17));
        chk("R7 clean read no traffic", log_n - base, 0);
        chk("R7 clean read no error", got_err, 0);
    endtask

    task automatic t_update_commit();
        int base;
        base = log_n;
        host_op(2'b10, 7'd20, 16'hAB12, 2'b01);
        host_op(2'b10, 7'd3,  16'h34FF, 2'b10);
        host_op(2'b10, 7'd9,  16'hBEEF, 2'b11);
        chk("R6 field updates cause no traffic", log_n - base, 0);
        host_op(2'b11, 7'd0, 16'h0, 2'b00);
        chk("R4 commit writes three entries", log_n - base, 3);
        chk("R4 first commit write is entry 3", log_cmd[base], 16'h0003);
        chk("R6 entry 3 high byte replaced", log_dat[base], {8'h34, def_val(3)[7:0]});
        chk("R4 second commit write is entry 9", log_cmd[base + 1], 16'h0009);
        chk("R6 entry 9 both bytes replaced", log_dat[base + 1], 16'hBEEF);
        chk("R4 third commit write is entry 20", log_cmd[base + 2], 16'h0014);
        chk("R6 entry 20 low byte replaced", log_dat[base + 2], {def_val(20)[15:8], 8'h12});
        base = log_n;
        host_op(2'b11, 7'd0, 16'h0, 2'b00);
        chk("R4 dirty flags cleared by commit", log_n - base, 0);
    endtask

    task automatic t_direct_write();
        int base;
        base = log_n;
        host_op(2'b01, 7'd12, 16'h1234, 2'b00);
        chk("R5 direct write one transfer", log_n - base, 1);
        chk("R3 write command word", log_cmd[base], 16'h000C);
        chk("R5 direct write data", log_dat[base], 16'h1234);
        host_op(2'b00, 7'd12, 16'h0, 2'b00);
        chk("R5 value cached after write", got_data, 16'h1234);
        host_op(2'b11, 7'd0, 16'h0, 2'b00);
        chk("R5 entry clean after direct write", log_n - base, 1);
    endtask

    task automatic t_dirty_read();
        int base;
        dev_mem[7] = 16'h7777;
        host_op(2'b10, 7'd7, 16'h0011, 2'b01);
        base = log_n;
        host_op(2'b00, 7'd7, 16'h0, 2'b00);
        chk("R8 dirty read goes to bus", log_n - base, 1);
        chk("R3 read command word", log_cmd[base], 16'h0087);
        chk("R3 read data word all ones", log_dat[base], 16'hFFFF);
        chk("R8 dirty read returns device word", got_data, 16'h7777);
        host_op(2'b11, 7'd0, 16'h0, 2'b00);
        chk("R8 pending change discarded", log_n - base, 1);
        host_op(2'b00, 7'd7, 16'h0, 2'b00);
        chk("R8 fetched value cached", got_data, 16'h7777);
        chk("R8 cached read after fetch no traffic", log_n - base, 1);
    endtask

    task automatic t_readback();
        int base;
        base = log_n;
        host_op(2'b00, 7'd31, 16'h0, 2'b00);
        chk("R9 first readback value", got_data, 16'hA000);
        host_op(2'b00, 7'd31, 16'h0, 2'b00);
        chk("R9 second readback value", got_data, 16'hA001);
        chk("R9 both readbacks on bus", log_n - base, 2);
        chk("R9 readback command word", log_cmd[base + 1], 16'h009F);
        chk("R9 readback no error", got_err, 0);
    endtask

    task automatic t_errors();
        int base;
        base = log_n;
        host_op(2'b01, 7'd40, 16'h1111, 2'b00);
        chk("R10 write to 40 flagged", got_err, 1);
        host_op(2'b10, 7'd31, 16'h2222, 2'b11);
        chk("R10 update to 31 flagged", got_err, 1);
        host_op(2'b00, 7'd33, 16'h0, 2'b00);
        chk("R10 read of 33 flagged", got_err, 1);
        host_op(2'b01, 7'd31, 16'h3333, 2'b00);
        chk("R10 write to 31 flagged", got_err, 1);
        chk("R10 rejected requests issue no transfer", log_n - base, 0);
        host_op(2'b11, 7'd0, 16'h0, 2'b00);
        chk("R10 rejected update left nothing dirty", log_n - base, 0);
    endtask

    task automatic t_stall();
        int base;
        host_op(2'b10, 7'd5, 16'hCAFE, 2'b11);
        base = log_n;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b11; req_addr = '0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_op = 2'b01; req_addr = 7'd6; req_wdata = 16'h0606;
        chk("R11 busy during commit", busy, 1);
        chk("R11 not ready during commit", req_ready, 0);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_rsp();
        chk("R11 commit then held write both on bus", log_n - base, 2);
        chk("R11 commit write first", log_cmd[base], 16'h0005);
        chk("R11 commit data", log_dat[base], 16'hCAFE);
        chk("R11 held write served after commit", log_cmd[base + 1], 16'h0006);
        chk("R11 held write data", log_dat[base + 1], 16'h0606);
        @(negedge clk);
        chk("R11 idle after stall scenario", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init();
        t_update_commit();
        t_direct_write();
        t_dirty_read();
        t_readback();
        t_errors();
        t_stall();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung handshake ends the run as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog R11 actual=hang expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule